// File: doc/BRIEF.md
# Two-Instruction Stall-Based Pipelined Core

A minimal in-order processor with three pipeline stages: instruction fetch, operand read, and execute/writeback. It understands two instructions. One adds one to a register. The other jumps to a code address when a register holds zero. Each pair of neighbouring stages is linked by a one-entry holding register with a presence flag. Every stage decides what to do from the state at the start of the cycle, so an instruction moves forward by one stage per clock when nothing blocks it.

A pending increment in the execute stage blocks operand read of any instruction that uses the same register. A stall is used in place of a bypass path. A taken zero-test jump redirects the program counter and empties both holding registers in the same cycle. Software loads the 256-word instruction store through a write port while the core is held in reset. The program counter and all eight registers are visible at output ports.

Top module: `pipe_core`

## Requirements
- R1: While reset is asserted, the program counter reads 0 and all eight 8-bit registers read 0. The first instruction fetch happens on the first rising edge after reset is released.
- R2: Instruction word encoding is 12 bits. Bit 11 is the opcode (0 = increment, 1 = jump-if-zero), bits 10:8 select the register, and bits 7:0 give the jump target. An increment fetched on edge N writes register+1 to its register, visible after edge N+2.
- R3: When nothing stalls, the program counter advances by one on every clock.
- R4: Operand read of either instruction type waits while the execute stage holds an increment of the same register. During that wait the program counter holds for one cycle, and the dependent instruction then sees the updated value.
- R5: A jump-if-zero whose register is nonzero has no effect other than leaving the pipeline. Execution continues at the next address.
- R6: A jump-if-zero whose register is zero sets the program counter to its target on the next edge. The same edge discards both instructions behind it, so neither of those ever changes a register. Fetch resumes from the target on the following edge.
- R7: Register values are 8 bits wide and wrap from 255 to 0 on increment.
- R8: The instruction store is written through the load port one word per clock, and it keeps its contents across reset.
- R9: Back-to-back increments of different registers cause no stall. The program counter advances on each of the first four edges after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the core state |
| imem_we_i | input | 1 | Instruction store write strobe |
| imem_waddr_i | input | 8 | Instruction store write address |
| imem_wdata_i | input | 12 | Instruction word to store |
| pc_o | output | 8 | Current program counter |
| rf_o | output | 64 | All registers, register i in bits 8i+7:8i |

## Verification
On every cycle, the in-module assertions check three things: the program counter steps by one whenever the fetch holder is empty, a detected hazard leaves the execute holder empty while the program counter holds, and a taken jump lands on its target with both holders cleared. They also check that every writeback reaches the addressed register. Other behaviour shows up only through the bench's whole programs, from the final register contents: that the stall yields the updated value, that discarded instructions never retire, the 8-bit wrap inside a loop, and that the store keeps its program across reset.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int RIDX_W = 3;
  localparam int NREG   = 2 ** RIDX_W;
  localparam int INSN_W = 1 + RIDX_W + ADDR_W;

  typedef enum logic {OP_INC = 1'b0, OP_JZ = 1'b1} op_e;

  typedef struct packed {
    op_e               op;
    logic [RIDX_W-1:0] rd;
    logic [ADDR_W-1:0] tgt;
  } insn_t;

  // execute-stage entry: operand value already read
  typedef struct packed {
    op_e               op;
    logic [RIDX_W-1:0] rd;
    logic [DATA_W-1:0] val;
    logic [ADDR_W-1:0] tgt;
  } exe_t;
endpackage

// File: rtl/insn_store.sv
module insn_store #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem_q [DEPTH];

  // no reset: contents survive core reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int NR = 8,
  parameter int DW = 8,
  localparam int IW = $clog2(NR)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [IW-1:0]  waddr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [IW-1:0]  raddr_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NR*DW-1:0] flat_o
);
  logic [DW-1:0] rf_q [NR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NR; i++) rf_q[i] <= '0;
    end else if (we_i) begin
      rf_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = rf_q[raddr_i];

  for (genvar g = 0; g < NR; g++) begin : g_flat
    assign flat_o[g*DW +: DW] = rf_q[g];
  end

  // R2
  wb_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rf_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/pipe_ctrl.sv
module pipe_ctrl
  import core_pkg::*;
(
  input  logic  b1_valid_i,
  input  insn_t b1_i,
  input  logic  b2_valid_i,
  input  exe_t  b2_i,
  output logic  taken_o,
  output logic  hazard_o,
  output logic  of_go_o,
  output logic  fetch_go_o,
  output logic  wb_inc_o
);
  // all decisions use start-of-cycle state
  assign taken_o    = b2_valid_i && (b2_i.op == OP_JZ) && (b2_i.val == '0);
  assign wb_inc_o   = b2_valid_i && (b2_i.op == OP_INC);
  assign hazard_o   = b1_valid_i && wb_inc_o && (b2_i.rd == b1_i.rd);
  // execute always drains b2, so operand fetch only waits on hazards
  assign of_go_o    = b1_valid_i && !hazard_o && !taken_o;
  assign fetch_go_o = !b1_valid_i || taken_o || of_go_o;
endmodule

// File: rtl/pipe_core.sv
module pipe_core
  import core_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   imem_we_i,
  input  logic [ADDR_W-1:0]      imem_waddr_i,
  input  logic [INSN_W-1:0]      imem_wdata_i,
  output logic [ADDR_W-1:0]      pc_o,
  output logic [NREG*DATA_W-1:0] rf_o
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              b1_valid_q, b1_valid_d;
  insn_t             b1_q, b1_d;
  logic              b2_valid_q, b2_valid_d;
  exe_t              b2_q, b2_d;

  logic [INSN_W-1:0] fetch_word;
  logic [DATA_W-1:0] opnd;
  logic taken, hazard, of_go, fetch_go, wb_inc;

  insn_store #(.AW(ADDR_W), .DW(INSN_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (imem_we_i),
    .waddr_i (imem_waddr_i),
    .wdata_i (imem_wdata_i),
    .raddr_i (pc_q),
    .rdata_o (fetch_word)
  );

  reg_bank #(.NR(NREG), .DW(DATA_W)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wb_inc),
    .waddr_i (b2_q.rd),
    .wdata_i (b2_q.val + 1'b1),
    .raddr_i (b1_q.rd),
    .rdata_o (opnd),
    .flat_o  (rf_o)
  );

  pipe_ctrl u_ctrl (
    .b1_valid_i (b1_valid_q),
    .b1_i       (b1_q),
    .b2_valid_i (b2_valid_q),
    .b2_i       (b2_q),
    .taken_o    (taken),
    .hazard_o   (hazard),
    .of_go_o    (of_go),
    .fetch_go_o (fetch_go),
    .wb_inc_o   (wb_inc)
  );

  always_comb begin
    pc_d       = pc_q;
    b1_valid_d = b1_valid_q;
    b1_d       = b1_q;
    b2_valid_d = 1'b0;
    b2_d       = b2_q;
    if (taken) begin
      // flush wins over fetch and operand fetch
      pc_d       = b2_q.tgt;
      b1_valid_d = 1'b0;
    end else begin
      if (fetch_go) begin
        pc_d       = pc_q + 1'b1;
        b1_valid_d = 1'b1;
        b1_d       = insn_t'(fetch_word);
      end
      if (of_go) begin
        b2_valid_d = 1'b1;
        b2_d       = '{op: b1_q.op, rd: b1_q.rd, val: opnd, tgt: b1_q.tgt};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      b1_valid_q <= 1'b0;
      b1_q       <= '0;
      b2_valid_q <= 1'b0;
      b2_q       <= '0;
    end else begin
      pc_q       <= pc_d;
      b1_valid_q <= b1_valid_d;
      b1_q       <= b1_d;
      b2_valid_q <= b2_valid_d;
      b2_q       <= b2_d;
    end
  end

  assign pc_o = pc_q;

  // R3
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!b1_valid_q && !taken) |=> pc_q == $past(pc_q) + 1'b1);

  // R4
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard |=> !b2_valid_q && $stable(pc_q));

  // R6
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken |=> pc_q == $past(b2_q.tgt) && !b1_valid_q && !b2_valid_q);

  // R9
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    of_go |=> b2_valid_q);
endmodule

// File: tb/pipe_core_tb.sv
module pipe_core_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        we;
  logic [7:0]  waddr;
  logic [11:0] wdata;
  logic [7:0]  pc;
  logic [63:0] rf;

  always #10 clk = ~clk;

  pipe_core u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .imem_we_i    (we),
    .imem_waddr_i (waddr),
    .imem_wdata_i (wdata),
    .pc_o         (pc),
    .rf_o         (rf)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam int NS = 5;
  localparam int ML = 6;
  // words: INC r = {0,r,8'h00}; JZ r,t = {1,r,t}; trap = JZ r6 to self
  localparam logic [11:0] PROG [NS][ML] = '{
    '{12'h100, 12'h200, 12'h100, 12'hE03, 12'h000, 12'h000},
    '{12'h300, 12'h300, 12'h300, 12'hE03, 12'h000, 12'h000},
    '{12'h803, 12'h100, 12'h100, 12'h200, 12'hE04, 12'h000},
    '{12'h400, 12'hC03, 12'h500, 12'hE03, 12'h000, 12'h000},
    '{12'h100, 12'h903, 12'h800, 12'h200, 12'hE04, 12'h000}
  };
  localparam int LEN [NS] = '{4, 4, 5, 4, 5};
  localparam int RUN [NS] = '{100, 100, 100, 100, 3000};
  localparam logic [63:0] EXP_RF [NS] = '{
    64'h0000_0000_0001_0200,
    64'h0000_0000_0300_0000,
    64'h0000_0000_0001_0000,
    64'h0000_0101_0000_0000,
    64'h0000_0000_0001_0000
  };

  function automatic string tag(int s);
    case (s)
      0:       return "R2 mixed increments";
      1:       return "R4 same-register chain";
      2:       return "R6 taken jump skips";
      3:       return "R5 untaken jump after stall";
      default: return "R7 wrap loop";
    endcase
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load(int s);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      we = 1'b1; waddr = 8'(a); wdata = 12'hE00 | 12'(a);
    end
    for (int i = 0; i < LEN[s]; i++) begin
      @(negedge clk);
      we = 1'b1; waddr = 8'(i); wdata = PROG[s][i];
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_ni = 1'b0;
  endtask

  task automatic start();
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; we = 1'b0; waddr = '0; wdata = '0;

    // scenario table
    for (int s = 0; s < NS; s++) begin
      hold_reset();
      load(s);
      start();
      repeat (RUN[s]) step();
      chk(tag(s), rf, EXP_RF[s]);
    end

    // R1 reset state, R8 program kept across reset
    hold_reset();
    step();
    chk("R1 pc in reset", {56'b0, pc}, 64'h0);
    chk("R1 regs in reset", rf, 64'h0);
    start();
    repeat (3000) step();
    chk("R8 rerun without reload", rf, EXP_RF[4]);

    // R3/R4 pc timing with same-register chain
    hold_reset();
    load(1);
    start();
    step(); chk("R3 pc edge1", {56'b0, pc}, 64'd1);
    step(); chk("R3 pc edge2", {56'b0, pc}, 64'd2);
    step(); chk("R4 pc holds on stall", {56'b0, pc}, 64'd2);
    chk("R2 first increment visible edge3", rf, 64'h0000_0000_0100_0000);
    step(); chk("R4 pc resumes", {56'b0, pc}, 64'd3);

    // R9 no stall for different registers
    hold_reset();
    load(0);
    start();
    for (int e = 1; e <= 4; e++) begin
      step();
      chk("R9 pc advance", {56'b0, pc}, 64'(e));
    end

    // R6 redirect and refetch
    hold_reset();
    load(2);
    start();
    step(); step();
    chk("R6 pc before jump", {56'b0, pc}, 64'd2);
    step();
    chk("R6 pc at target", {56'b0, pc}, 64'd3);
    chk("R6 no register change", rf, 64'h0);
    step();
    chk("R6 fetch resumes", {56'b0, pc}, 64'd4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule